// File: doc/BRIEF.md
# Vector Byte-Lane Reversal and Count Unit

This unit runs one of three lane-wise operations on a 128-bit vector operand. It decodes a 32-bit instruction word, picks the operation, and writes back a registered result with a destination register index and a write enable. The three operations are:

- **Bit flip.** Mirrors the bit order inside every byte.
- **Element swap.** Reverses the order of byte, halfword or word elements inside 16-, 32- or 64-bit containers. The containers themselves stay in place.
- **Population count.** Gives the number of set bits in each byte.

A width bit in the instruction chooses between the full 128-bit form and a 64-bit form. The 64-bit form reads only the low half of the operand and forces the high half of the result to zero.

The unit sits between a register-file read port and a write-back port. The caller presents an instruction, its operand and a one-cycle strobe. The result comes back exactly one clock later. Encodings that are not recognised, and reserved size combinations, are never executed. They raise an illegal flag, keep the write enable low and return a zero result.

Top module: `vrev_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and is low after any cycle in which `in_valid` is low.
- R2: While the synchronous active-high `rst` is high, `out_valid`, `out_wen` and `out_illegal` go low at the next clock edge, even if `in_valid` is high.
- R3: Instruction bit 30 selects the width: 1 is 128-bit and 0 is 64-bit. In 64-bit form, result bits 127:64 are zero and operand bits 127:64 have no effect on the result.
- R4: The bit flip is any word equal to 0x2E605800 under the mask 0xBFFFFC00. Every active byte of the result holds the operand byte with bit i moved to bit 7-i.
- R5: The element swap is any word equal to 0x0E200800 under the mask 0x9F3FEC00. The container code is {bit 12, bit 29}: 10 gives 16 bits, 01 gives 32 bits and 00 gives 64 bits. The element width is 8 << bits 23:22. Within each container, element k goes to position (elements per container - 1 - k).
- R6: An element swap whose container code is 11, or whose container code plus size field (both read as unsigned numbers) is 3 or more, is treated as illegal.
- R7: The population count is any word equal to 0x0E205800 under the mask 0xBFFFFC00. Every active result byte holds the number of set bits (0 to 8) in the matching operand byte.
- R8: An unrecognised or illegal word gives `out_illegal`=1, `out_wen`=0 and an all-zero result.
- R9: A legal word gives `out_wen`=1 and `out_illegal`=0. For every word, `out_rd` equals instruction bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and operand are present |
| instr | input | 32 | Instruction word |
| src | input | 128 | Source vector operand |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | 128 | Result vector |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Write enable for a legal operation |
| out_illegal | output | 1 | Word was unrecognised or reserved |

## Verification
Every output of this block comes from one register stage, so each result is due exactly one clock after the edge that samples its strobe. Back-to-back strobes give back-to-back results in the same order. The bench pushes an expected entry when it drives a strobe and pops it only when `out_valid` is seen. Both actions happen at the falling edge, so the pop lands in the cycle after the push. A result with no pending entry, or an entry left over at the end, shows a latency or strobe fault.

// File: rtl/vrev_pkg.sv
package vrev_pkg;
  localparam int BYTE_W     = 8;
  localparam int CONT_LOG2  = 3;  // largest container is 2**3 bytes

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_FLIP  = 2'd1,
    K_SWAP  = 2'd2,
    K_COUNT = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e                kind;
    logic                 wide;
    logic [CONT_LOG2-1:0] xmask;  // byte-index XOR for element swap
    logic [4:0]           rd;
  } dec_t;
endpackage

// File: rtl/vrev_decode.sv
module vrev_decode
  import vrev_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  localparam logic [INSTR_W-1:0] FLIP_MASK = 32'hBFFF_FC00;
  localparam logic [INSTR_W-1:0] FLIP_VAL  = 32'h2E60_5800;
  localparam logic [INSTR_W-1:0] CNT_VAL   = 32'h0E20_5800;
  localparam logic [INSTR_W-1:0] SWAP_MASK = 32'h9F3F_EC00;
  localparam logic [INSTR_W-1:0] SWAP_VAL  = 32'h0E20_0800;

  logic [1:0] cont_code;
  logic [1:0] size_f;
  logic [2:0] code_sum;
  logic       hit_flip, hit_cnt, hit_swap, swap_ok;
  logic [CONT_LOG2:0] cont_ones, elem_ones;

  always_comb begin
    cont_code = {instr[12], instr[29]};
    size_f    = instr[23:22];
    code_sum  = {1'b0, cont_code} + {1'b0, size_f};
    hit_flip  = (instr & FLIP_MASK) == FLIP_VAL;
    hit_cnt   = (instr & FLIP_MASK) == CNT_VAL;
    hit_swap  = (instr & SWAP_MASK) == SWAP_VAL;
    swap_ok   = hit_swap && (cont_code != 2'b11) && (code_sum < 3'd3);

    // container bytes-1 XOR element bytes-1 gives the byte index flip mask
    cont_ones = (4'd1 << (2'd3 - cont_code)) - 4'd1;
    elem_ones = (4'd1 << size_f) - 4'd1;

    dec.wide  = instr[30];
    dec.rd    = instr[4:0];
    dec.xmask = cont_ones[CONT_LOG2-1:0] ^ elem_ones[CONT_LOG2-1:0];
    if (hit_flip)     dec.kind = K_FLIP;
    else if (hit_cnt) dec.kind = K_COUNT;
    else if (swap_ok) dec.kind = K_SWAP;
    else              dec.kind = K_NONE;
  end
endmodule

// File: rtl/vrev_lanes.sv
module vrev_lanes
  import vrev_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] result
);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALF   = LANES / 2;
  localparam int LIDX_W = $clog2(LANES);

  logic [DATA_W-1:0] opnd;

  always_comb begin
    opnd = src;
    if (!dec.wide) opnd[DATA_W-1:DATA_W/2] = '0;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [BYTE_W-1:0] own, moved, flipped, cnt, s1, s2;
    logic [LIDX_W-1:0] from;

    assign own  = opnd[j*BYTE_W +: BYTE_W];
    assign from = LIDX_W'(j) ^ LIDX_W'(dec.xmask);
    assign moved = opnd[from*BYTE_W +: BYTE_W];

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign flipped[b] = own[BYTE_W-1-b];
    end

    // pairwise adder tree: 1-bit pairs, 2-bit pairs, nibbles
    assign s1  = ((own >> 1) & 8'h55) + (own & 8'h55);
    assign s2  = ((s1  >> 2) & 8'h33) + (s1  & 8'h33);
    assign cnt = (s2 >> 4) + (s2 & 8'h0F);

    always_comb begin
      if (!dec.wide && j >= HALF) begin
        result[j*BYTE_W +: BYTE_W] = '0;
      end else begin
        unique case (dec.kind)
          K_FLIP:  result[j*BYTE_W +: BYTE_W] = flipped;
          K_COUNT: result[j*BYTE_W +: BYTE_W] = cnt;
          K_SWAP:  result[j*BYTE_W +: BYTE_W] = moved;
          default: result[j*BYTE_W +: BYTE_W] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
  import vrev_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int INSTR_W = 32,
  parameter int RIDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_result,
  output logic [RIDX_W-1:0]  out_rd,
  output logic               out_wen,
  output logic               out_illegal
);
  dec_t              dec;
  logic [DATA_W-1:0] lane_res;
  logic              legal;

  vrev_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  vrev_lanes #(.DATA_W(DATA_W)) u_lanes (
    .dec    (dec),
    .src    (src),
    .result (lane_res)
  );

  assign legal = (dec.kind != K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= in_valid && legal;
      out_illegal <= in_valid && !legal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_result <= lane_res;
      out_rd     <= RIDX_W'(dec.rd);
    end
  end
endmodule

// File: rtl/vrev_unit_checks.sv
module vrev_unit_checks #(
  parameter int DATA_W  = 128,
  parameter int INSTR_W = 32,
  parameter int RIDX_W  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_result,
  input logic [RIDX_W-1:0]  out_rd,
  input logic               out_wen,
  input logic               out_illegal
);
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_quiet_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_reset_clears_r2: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_wen && !out_illegal));

  p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[30]) |=> (out_result[DATA_W-1:DATA_W/2] == '0));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wen && out_result == '0));

  p_flag_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_wen ^ out_illegal));

  p_no_flag_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_wen && !out_illegal));

  p_dest_index_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_rd == $past(instr[RIDX_W-1:0])));
endmodule

bind vrev_unit vrev_unit_checks #(
  .DATA_W(DATA_W), .INSTR_W(INSTR_W), .RIDX_W(RIDX_W)
) u_checks (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_rd      (out_rd),
  .out_wen     (out_wen),
  .out_illegal (out_illegal)
);

// File: tb/vrev_unit_test.sv
module vrev_unit_test;
  typedef struct packed {
    logic [127:0] res;
    logic [4:0]   rd;
    logic         wen;
    logic         ill;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [4:0]   out_rd;
  logic         out_wen;
  logic         out_illegal;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  vrev_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(out_valid), .out_result(out_result), .out_rd(out_rd),
    .out_wen(out_wen), .out_illegal(out_illegal)
  );

  function automatic exp_t model(input logic [31:0] ins, input logic [127:0] s);
    exp_t r;
    logic [127:0] a;
    int dbits, op, sz, cb, eb, n, d;
    logic [7:0] c;
    r.rd = ins[4:0]; r.res = '0; r.wen = 1'b0; r.ill = 1'b1;
    dbits = ins[30] ? 128 : 64;
    a = s;
    if (!ins[30]) a[127:64] = '0;
    if ((ins & 32'hBFFFFC00) == 32'h2E605800) begin
      r.wen = 1'b1; r.ill = 1'b0;
      for (int b = 0; b < dbits / 8; b++)
        for (int i = 0; i < 8; i++) r.res[b*8 + 7 - i] = a[b*8 + i];
    end else if ((ins & 32'hBFFFFC00) == 32'h0E205800) begin
      r.wen = 1'b1; r.ill = 1'b0;
      for (int b = 0; b < dbits / 8; b++) begin
        c = 0;
        for (int i = 0; i < 8; i++) c = c + 8'(a[b*8 + i]);
        r.res[b*8 +: 8] = c;
      end
    end else if ((ins & 32'h9F3FEC00) == 32'h0E200800) begin
      op = int'({ins[12], ins[29]});
      sz = int'(ins[23:22]);
      if (op != 3 && op + sz < 3) begin
        r.wen = 1'b1; r.ill = 1'b0;
        cb = (op == 2) ? 16 : (op == 1) ? 32 : 64;
        eb = 8 << sz;
        n  = cb / eb;
        for (int e = 0; e < dbits / eb; e++) begin
          d = (e / n) * n + (n - 1 - e % n);
          for (int k = 0; k < eb; k++) r.res[d*eb + k] = a[e*eb + k];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] regs(input logic [31:0] base);
    return base | {22'd0, 5'($urandom), 5'($urandom)};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [127:0] s, input string tag);
    @(negedge clk);
    instr = ins; src = s; in_valid = 1'b1;
    exp_q.push_back(model(ins, s));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cyc - 1) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // monitor: pops one expected item per observed result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", 128'(out_valid), 128'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_result == e.res, {t, " result"}, out_result, e.res);
        check(out_wen == e.wen && out_illegal == e.ill, {t, " R8/R9 flags"},
              128'({out_wen, out_illegal}), 128'({e.wen, e.ill}));
        check(out_rd == e.rd, {t, " R9 rd"}, 128'(out_rd), 128'(e.rd));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 128'd0, 128'd1);
    finish_run();
  end

  initial begin
    logic [127:0] pats[5];
    logic [31:0]  base;
    string        t;

    // R2: reset holds flags low even with a strobe present
    @(negedge clk);
    in_valid = 1'b1; instr = 32'h2E605800;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_wen && !out_illegal, "R2 reset state",
          128'({out_valid, out_wen, out_illegal}), 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {16{8'hAA}};
    pats[3] = {16{8'h55}};
    for (int q = 0; q < 2; q++) begin
      for (int p = 0; p < 5; p++) begin
        pats[4] = rnd128();
        send(regs(32'h2E605800 | (32'(q) << 30)), pats[p], "R4/R3 bit flip");
        send(regs(32'h0E205800 | (32'(q) << 30)), pats[p], "R7/R3 popcount");
        for (int op = 0; op < 4; op++) begin
          for (int sz = 0; sz < 4; sz++) begin
            base = 32'h0E200800 | (32'(q) << 30) | (32'(op >> 1) << 12)
                 | (32'(op & 1) << 29) | (32'(sz) << 22);
            t = (op == 3 || op + sz >= 3) ? "R6 reserved swap" : "R5/R3 element swap";
            send(regs(base), pats[p], t);
          end
        end
        if (p == 2) idle(3);
      end
    end

    // R3: narrow form ignores the upper operand half
    send(regs(32'h0E201800), {64'hDEAD_BEEF_0123_4567, 64'h0011_2233_4455_6677}, "R3 upper ignored");
    send(regs(32'h2E605800), {64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0408_1020_4080}, "R3 upper ignored");
    // R8: words that match nothing
    send(32'h0000_0000, rnd128(), "R8 zero word");
    send(32'hFFFF_FFFF, rnd128(), "R8 all-ones word");
    send(regs(32'h2E205800), rnd128(), "R8 wrong size flip");
    send(regs(32'h0E205C00), rnd128(), "R8 near-miss count");
    send(regs(32'h0E201820 | 32'h4000_0000), 128'h0F0E0D0C0B0A09080706050403020100, "R5 16-bit bytes");
    idle(4);

    check(exp_q.size() == 0 && !out_valid, "R1 drained and idle",
          128'(exp_q.size()), 128'd0);
    finish_run();
  end
endmodule